// File: doc/BRIEF.md
# Seconds-counter RTC with match interrupt

This block is a memory-mapped real-time clock that sits on a simple APB-style register bus with zero wait states. A divider turns the reference clock into a one-second tick, and a 32-bit seconds counter advances by one on each tick while the run bit is set. Software can overwrite the running count at any time, and it can program a match value.

When a tick brings the count equal to the match value, a sticky alarm flag is raised. The flag is gated by a mask bit to form the interrupt output. Software reads the flag in raw or masked form and drops it by writing a one to a clear location. The divide ratio is a parameter. Its default of 32768 suits a 32.768 kHz reference.

Top module: `rtc_match_timer`

## Requirements
- R1: After reset the count, match value, mask bit, raw alarm flag and run bit all read zero, and `irq_o` is low.
- R2: While the run bit (control offset 0x0C, bit 0) is set, the count increases by one every TICK_DIV clocks. The first increment lands TICK_DIV clocks after the write that sets the run bit, because the divider restarts from zero while the run bit is clear.
- R3: While the run bit is clear, the count keeps its value.
- R4: A write to the load offset 0x08 replaces the count, and the new value reads back at the data offset 0x00. A load that lands on a tick clock takes precedence over the increment.
- R5: The match value is written and read back at offset 0x04.
- R6: Raw alarm flag (offset 0x14, bit 0): it rises on the tick clock where the count steps to the match value, and not earlier. It then stays set until it is cleared.
- R7: The masked status (offset 0x18, bit 0) equals the raw flag ANDed with the mask bit (offset 0x10, bit 0). `irq_o` follows the masked status.
- R8: Writing bit 0 = 1 to the clear offset 0x1C drops the raw flag. Writing 0 there leaves it unchanged.
- R9: If a clear write lands on the same clock as an alarm set, the flag ends up set.
- R10: Unmapped offsets and the clear offset read as zero. Writes to the data, raw and masked offsets are ignored. The control and mask offsets hold and return only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, also the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus direction, 1 = write |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Alarm interrupt (masked status) |

## Verification
The assertions assume that a write is committed on exactly one clock, the one where select, enable and write are all high. They also assume that the reset is released away from a clock edge. The bench follows these rules. It raises the access phase for one clock after a setup phase, and it changes every input on the falling edge. The bench overrides TICK_DIV to 16 so that many ticks fit in a short run. It times the clear and load writes to land on the exact tick clock, which exercises the priority rules.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFF_DATA   = 'h00;
  localparam int unsigned OFF_MATCH  = 'h04;
  localparam int unsigned OFF_LOAD   = 'h08;
  localparam int unsigned OFF_CTRL   = 'h0C;
  localparam int unsigned OFF_MASK   = 'h10;
  localparam int unsigned OFF_RAW    = 'h14;
  localparam int unsigned OFF_MASKED = 'h18;
  localparam int unsigned OFF_CLEAR  = 'h1C;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  // divider phase restarts whenever the clock is stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] match_i,
  output logic [CW-1:0] count_o,
  output logic          hit_o
);
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_nxt;
  logic          step;

  assign step      = en_i && tick_i && !load_i;
  assign count_nxt = count_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (step)   count_q <= count_nxt;
  end

  assign count_o = count_q;
  assign hit_o   = step && (count_nxt == match_i);

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i)); // R4
  AST_STEP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !load_i) |=> count_o == $past(count_o) + CW'(1)); // R2
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_o)); // R3
  AST_HIT_AT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> count_o == $past(match_i)); // R6
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_wr_i,
  input  logic mask_d_i,
  output logic raw_o,
  output logic mask_o,
  output logic masked_o
);
  logic raw_q, mask_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    raw_q <= 1'b0;
    else if (set_i) raw_q <= 1'b1;
    else if (clr_i) raw_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= 1'b0;
    else if (mask_wr_i) mask_q <= mask_d_i;
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> raw_o); // R9
  AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o && !clr_i) |=> raw_o); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw_o && !set_i) |=> !raw_o); // R6
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !raw_o); // R8
endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o
);
  logic wr_en;
  logic wr_match, wr_load, wr_ctrl, wr_mask, wr_clear;
  logic run_q;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] count;
  logic tick, hit;
  logic raw, mask, masked;

  assign wr_en    = psel_i && penable_i && pwrite_i;
  assign wr_match = wr_en && (paddr_i == ADDR_W'(OFF_MATCH));
  assign wr_load  = wr_en && (paddr_i == ADDR_W'(OFF_LOAD));
  assign wr_ctrl  = wr_en && (paddr_i == ADDR_W'(OFF_CTRL));
  assign wr_mask  = wr_en && (paddr_i == ADDR_W'(OFF_MASK));
  assign wr_clear = wr_en && (paddr_i == ADDR_W'(OFF_CLEAR)) && pwdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      match_q <= '0;
    end else begin
      if (wr_ctrl)  run_q   <= pwdata_i[0];
      if (wr_match) match_q <= pwdata_i;
    end
  end

  rtc_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .tick_o(tick)
  );

  rtc_seconds #(.CW(DATA_W)) u_secs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (run_q),
    .tick_i    (tick),
    .load_i    (wr_load),
    .load_val_i(pwdata_i),
    .match_i   (match_q),
    .count_o   (count),
    .hit_o     (hit)
  );

  rtc_alarm_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hit),
    .clr_i    (wr_clear),
    .mask_wr_i(wr_mask),
    .mask_d_i (pwdata_i[0]),
    .raw_o    (raw),
    .mask_o   (mask),
    .masked_o (masked)
  );

  assign irq_o = masked;

  always_comb begin
    prdata_o = '0;
    if (paddr_i == ADDR_W'(OFF_DATA))        prdata_o = count;
    else if (paddr_i == ADDR_W'(OFF_MATCH))  prdata_o = match_q;
    else if (paddr_i == ADDR_W'(OFF_CTRL))   prdata_o = DATA_W'(run_q);
    else if (paddr_i == ADDR_W'(OFF_MASK))   prdata_o = DATA_W'(mask);
    else if (paddr_i == ADDR_W'(OFF_RAW))    prdata_o = DATA_W'(raw);
    else if (paddr_i == ADDR_W'(OFF_MASKED)) prdata_o = DATA_W'(masked);
  end

  AST_MATCH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_match |=> match_q == $past(pwdata_i)); // R5
  AST_MATCH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_match |=> $stable(match_q)); // R5
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mask && !pwdata_i[0]) |=> !irq_o); // R7
endmodule

// File: tb/rtc_match_timer_tb_top.sv
module rtc_match_timer_tb_top;
  localparam int DIV = 16;
  localparam logic [11:0] A_DATA = 12'h00, A_MATCH = 12'h04, A_LOAD = 12'h08,
                          A_CTRL = 12'h0C, A_MASK = 12'h10, A_RAW = 12'h14,
                          A_MSKD = 12'h18, A_CLR = 12'h1C, A_NONE = 12'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_match_timer #(.DATA_W(32), .ADDR_W(12), .TICK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .irq_o(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #2;
    d = prdata;
    psel = 1'b0;
  endtask

  task automatic expect_reg(string req, string what, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1", "count", A_DATA, 0);
    expect_reg("R1", "match", A_MATCH, 0);
    expect_reg("R1", "ctrl", A_CTRL, 0);
    expect_reg("R1", "mask", A_MASK, 0);
    expect_reg("R1", "raw", A_RAW, 0);
    chk("R1", "irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count();
    wr(A_LOAD, 32'd5);
    expect_reg("R4", "load while stopped", A_DATA, 5);
    wr(A_CTRL, 1);
    repeat (DIV - 1) @(negedge clk);
    expect_reg("R2", "before first tick", A_DATA, 5);
    @(negedge clk);
    expect_reg("R2", "first tick", A_DATA, 6);
    repeat (DIV) @(negedge clk);
    expect_reg("R2", "second tick", A_DATA, 7);
  endtask

  task automatic t_hold();
    wr(A_CTRL, 0);
    repeat (3 * DIV) @(negedge clk);
    expect_reg("R3", "hold while stopped", A_DATA, 7);
    wr(A_DATA, 32'd99);
    expect_reg("R10", "data write ignored", A_DATA, 7);
  endtask

  task automatic t_load_prio();
    wr(A_CTRL, 1);
    repeat (DIV - 2) @(negedge clk);
    wr(A_LOAD, 32'd50);
    expect_reg("R4", "load beats tick", A_DATA, 50);
    repeat (DIV - 1) @(negedge clk);
    expect_reg("R4", "after load before tick", A_DATA, 50);
    @(negedge clk);
    expect_reg("R4", "step after load", A_DATA, 51);
  endtask

  task automatic t_alarm();
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'd200);
    wr(A_MATCH, 32'd202);
    expect_reg("R5", "match readback", A_MATCH, 202);
    wr(A_MASK, 1);
    wr(A_CTRL, 1);
    repeat (DIV) @(negedge clk);
    expect_reg("R6", "count 201", A_DATA, 201);
    expect_reg("R6", "no early raw", A_RAW, 0);
    repeat (DIV - 1) @(negedge clk);
    expect_reg("R6", "raw before match tick", A_RAW, 0);
    chk("R7", "irq before match", {31'b0, irq}, 0);
    @(negedge clk);
    expect_reg("R6", "raw at match", A_RAW, 1);
    expect_reg("R7", "masked at match", A_MSKD, 1);
    chk("R7", "irq at match", {31'b0, irq}, 1);
    repeat (DIV) @(negedge clk);
    expect_reg("R6", "raw sticky", A_RAW, 1);
  endtask

  task automatic t_mask_clear();
    wr(A_MASK, 0);
    chk("R7", "irq masked off", {31'b0, irq}, 0);
    expect_reg("R7", "masked status off", A_MSKD, 0);
    expect_reg("R7", "raw kept under mask", A_RAW, 1);
    wr(A_CLR, 0);
    expect_reg("R8", "clear with 0", A_RAW, 1);
    wr(A_CLR, 1);
    expect_reg("R8", "clear with 1", A_RAW, 0);
  endtask

  task automatic t_set_wins();
    wr(A_CTRL, 0);
    wr(A_LOAD, 32'd300);
    wr(A_MATCH, 32'd301);
    wr(A_MASK, 1);
    wr(A_CTRL, 1);
    repeat (DIV - 2) @(negedge clk);
    wr(A_CLR, 1);
    expect_reg("R9", "count at collision", A_DATA, 301);
    expect_reg("R9", "set beats clear", A_RAW, 1);
    chk("R9", "irq after collision", {31'b0, irq}, 1);
  endtask

  task automatic t_ignored();
    wr(A_CTRL, 0);
    wr(A_CLR, 1);
    wr(A_RAW, 1);
    expect_reg("R10", "raw write ignored", A_RAW, 0);
    wr(A_MSKD, 1);
    expect_reg("R10", "masked write ignored", A_MSKD, 0);
    expect_reg("R10", "unmapped reads zero", A_NONE, 0);
    expect_reg("R10", "clear reads zero", A_CLR, 0);
    wr(A_MASK, 32'hFFFF_FFFF);
    expect_reg("R10", "mask only bit0", A_MASK, 1);
    wr(A_CTRL, 32'hFFFF_FFFE);
    expect_reg("R10", "ctrl only bit0", A_CTRL, 0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    expect_reg("R10", "ctrl bit0 set", A_CTRL, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_hold();
    t_load_prio();
    t_alarm();
    t_mask_clear();
    t_set_wins();
    t_ignored();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule